// File: doc/BRIEF.md
# Timer Global Slice Control Register Bank

This block holds the shared control state of a timer unit with four slices. A simple register bus writes it and reads it. It keeps a run/idle state for each slice and a run flag for the common prescaler. Each slice has three pending shadow-transfer request flags, for period/compare, dither and prescaler, plus one status bit that software owns. Each piece of state has its own write-one-to-set view, write-one-to-clear view and read-only view. The counters and the transfer of the shadow values sit outside this block. The logic that completes a transfer reports back on one acknowledge pin for each flag.

An external multi-channel trigger pin for each slice can also raise that slice's requests. A per-slice enable gates it, and a depth field chooses which of the three flags it raises. The prescaler can be set to stop and clear itself in the same clock edge in which a chosen slice stops.

The bus is a single-cycle register port. A write takes effect at the clock edge where `bus_wr` is high. `bus_rdata` is a combinational view of the word at `bus_addr`, so it never stalls and needs no valid/ready handshake. All other pins are plain level signals. The addresses are word indices: 0 is the configuration word, 1 is run-go, 2 is run-halt, 3 is run status, 4 is request-set, 5 is request-clear and 6 is request status. Any other address reads 0.

Top module: `tmr_glb_ctrl`

## Requirements
- R1: The run state of each slice is held in an idle bit. Writing 1 to bit i of the run-go word (address 1) sets `slice_run[i]` from the next cycle. Writing 1 to bit i of the run-halt word (address 2) clears it. Bits written as 0 change nothing. The run status word (address 3) shows the idle bits in bits 3:0, where 1 means idle.
- R2: The prescaler run flag `psc_run` is set by bit 8 of the run-go word and cleared by bit 8 of the run-halt word. It reads back in bit 8 of the run status word.
- R3: Writing 1 to bit 9 of the run-halt word makes `psc_clr` high for exactly the next cycle.
- R4: The configuration word bits 2:0 select an automatic prescaler clear. Code 0 disables it. With code k from 1 to 4, the clock edge in which slice k-1 goes from running to idle also clears `psc_run` and makes `psc_clr` high for the following cycle. Codes 5 to 7 act like code 0.
- R5: In the request-set word (address 4) and the request-clear word (address 5), slice i uses bit 3i for period/compare, bit 3i+1 for dither and bit 3i+2 for prescaler. The request status word (address 6) shows the pending flags at the same positions. If any source sets a flag in the same cycle as a clear, the set wins.
- R6: A pending flag whose acknowledge pin is high at a clock edge reads 0 from the next cycle on. If a set arrives in the same cycle as the acknowledge, the flag stays 1.
- R7: Configuration bit 4+i enables `mc_req[i]`. While that bit is 0, `mc_req[i]` has no effect on any of slice i's flags.
- R8: Configuration bits 13:12 choose the depth of an enabled trigger. Code 0 raises period/compare only. Codes 1 and 2 also raise prescaler. Code 3 raises all three flags.
- R9: Bit 16+i of the request-set word sets the software status bit `sw_stat[i]`, and the same bit of the request-clear word clears it. Set wins. Request status bit 16+i shows it.
- R10: After reset every slice is idle and the prescaler is stopped. All flags and all configuration fields are 0. Addresses 1, 2, 4, 5 and any unmapped address read 0. The configuration word reads back what was written to its fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe for the current cycle |
| bus_addr | input | 4 | Word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data of `bus_addr` |
| mc_req | input | 4 | Multi-channel trigger, one per slice |
| ack_pc | input | 4 | Period/compare transfer done |
| ack_dith | input | 4 | Dither transfer done |
| ack_psc | input | 4 | Prescaler transfer done |
| slice_run | output | 4 | Slice running |
| psc_run | output | 1 | Prescaler running |
| psc_clr | output | 1 | One-cycle prescaler count clear |
| pend_pc | output | 4 | Period/compare request pending |
| pend_dith | output | 4 | Dither request pending |
| pend_psc | output | 4 | Prescaler request pending |
| sw_stat | output | 4 | Software status bits |

## Verification
Some rules hold on every cycle, and the assertions check those. A set always leaves its flag at 1. A clear or acknowledge without a set leaves the flag at 0. A disabled trigger never raises a flag. Full-depth triggers always raise dither. A halt or count clear always reaches the prescaler outputs one cycle later. The selected slice stopping always stops and clears the prescaler. Other behaviour only the bench scenarios can show. These are the exact bit positions in the read words, the reset contents, reserved depth and select codes, and whole sequences. In one such sequence a trigger collides with a software clear, or an acknowledge collides with a set, and the result must match a model built from the requirements.

// File: rtl/tgc_pkg.sv
package tgc_pkg;
  localparam int AW = 4;
  localparam int DW = 32;

  localparam logic [AW-1:0] A_CFG      = 4'd0;
  localparam logic [AW-1:0] A_RUN_GO   = 4'd1;
  localparam logic [AW-1:0] A_RUN_HALT = 4'd2;
  localparam logic [AW-1:0] A_RUN_STAT = 4'd3;
  localparam logic [AW-1:0] A_REQ_SET  = 4'd4;
  localparam logic [AW-1:0] A_REQ_CLR  = 4'd5;
  localparam logic [AW-1:0] A_REQ_STAT = 4'd6;

  localparam int SEL_LSB    = 0;
  localparam int MCEN_LSB   = 4;
  localparam int DEPTH_LSB  = 12;
  localparam int PSC_BIT    = 8;
  localparam int CNTCLR_BIT = 9;
  localparam int STS_LSB    = 16;

  localparam int SLOT_PC   = 0;
  localparam int SLOT_DITH = 1;
  localparam int SLOT_PSC  = 2;
  localparam int SLOTS     = 3;

  typedef enum logic [1:0] {
    DEP_PC     = 2'd0,
    DEP_PC_PSC = 2'd1,
    DEP_RSVD   = 2'd2,
    DEP_ALL    = 2'd3
  } depth_e;
endpackage

// File: rtl/tgc_flag.sv
module tgc_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic ack_i,
  output logic q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             q_o <= 1'b0;
    else if (set_i)         q_o <= 1'b1;
    else if (clr_i || ack_i) q_o <= 1'b0;
  end

  // R5
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q_o);
  // R5
  clr_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !q_o);
  // R6
  ack_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !set_i) |=> !q_o);
endmodule

// File: rtl/tgc_regif.sv
module tgc_regif
  import tgc_pkg::*;
#(
  parameter int NSLICE = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic [$clog2(NSLICE+1)-1:0] sel_o,
  output logic [NSLICE-1:0] mcen_o,
  output depth_e            depth_o,
  output logic [NSLICE-1:0] go_o,
  output logic [NSLICE-1:0] halt_o,
  output logic              psc_go_o,
  output logic              psc_halt_o,
  output logic              cnt_clr_o,
  output logic [NSLICE-1:0] set_pc_o,
  output logic [NSLICE-1:0] set_dith_o,
  output logic [NSLICE-1:0] set_psc_o,
  output logic [NSLICE-1:0] clr_pc_o,
  output logic [NSLICE-1:0] clr_dith_o,
  output logic [NSLICE-1:0] clr_psc_o,
  output logic [NSLICE-1:0] sts_set_o,
  output logic [NSLICE-1:0] sts_clr_o,
  input  logic [NSLICE-1:0] idle_i,
  input  logic              psc_run_i,
  input  logic [NSLICE-1:0] pc_i,
  input  logic [NSLICE-1:0] dith_i,
  input  logic [NSLICE-1:0] psc_i,
  input  logic [NSLICE-1:0] sts_i
);
  localparam int SELW = $clog2(NSLICE+1);

  logic wr_cfg, wr_go, wr_halt, wr_set, wr_clr;
  logic unused_bits;

  assign wr_cfg  = bus_wr && (bus_addr == A_CFG);
  assign wr_go   = bus_wr && (bus_addr == A_RUN_GO);
  assign wr_halt = bus_wr && (bus_addr == A_RUN_HALT);
  assign wr_set  = bus_wr && (bus_addr == A_REQ_SET);
  assign wr_clr  = bus_wr && (bus_addr == A_REQ_CLR);
  assign unused_bits = ^bus_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_o   <= '0;
      mcen_o  <= '0;
      depth_o <= DEP_PC;
    end else if (wr_cfg) begin
      sel_o   <= bus_wdata[SEL_LSB +: SELW];
      mcen_o  <= bus_wdata[MCEN_LSB +: NSLICE];
      depth_o <= depth_e'(bus_wdata[DEPTH_LSB +: 2]);
    end
  end

  assign go_o       = wr_go   ? bus_wdata[NSLICE-1:0] : '0;
  assign halt_o     = wr_halt ? bus_wdata[NSLICE-1:0] : '0;
  assign psc_go_o   = wr_go   && bus_wdata[PSC_BIT];
  assign psc_halt_o = wr_halt && bus_wdata[PSC_BIT];
  assign cnt_clr_o  = wr_halt && bus_wdata[CNTCLR_BIT];

  for (genvar i = 0; i < NSLICE; i++) begin : g_strb
    assign set_pc_o[i]   = wr_set && bus_wdata[SLOTS*i+SLOT_PC];
    assign set_dith_o[i] = wr_set && bus_wdata[SLOTS*i+SLOT_DITH];
    assign set_psc_o[i]  = wr_set && bus_wdata[SLOTS*i+SLOT_PSC];
    assign clr_pc_o[i]   = wr_clr && bus_wdata[SLOTS*i+SLOT_PC];
    assign clr_dith_o[i] = wr_clr && bus_wdata[SLOTS*i+SLOT_DITH];
    assign clr_psc_o[i]  = wr_clr && bus_wdata[SLOTS*i+SLOT_PSC];
    assign sts_set_o[i]  = wr_set && bus_wdata[STS_LSB+i];
    assign sts_clr_o[i]  = wr_clr && bus_wdata[STS_LSB+i];
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CFG: begin
        bus_rdata[SEL_LSB +: SELW]    = sel_o;
        bus_rdata[MCEN_LSB +: NSLICE] = mcen_o;
        bus_rdata[DEPTH_LSB +: 2]     = depth_o;
      end
      A_RUN_STAT: begin
        bus_rdata[NSLICE-1:0] = idle_i;
        bus_rdata[PSC_BIT]    = psc_run_i;
      end
      A_REQ_STAT: begin
        for (int i = 0; i < NSLICE; i++) begin
          bus_rdata[SLOTS*i+SLOT_PC]   = pc_i[i];
          bus_rdata[SLOTS*i+SLOT_DITH] = dith_i[i];
          bus_rdata[SLOTS*i+SLOT_PSC]  = psc_i[i];
          bus_rdata[STS_LSB+i]         = sts_i[i];
        end
      end
      default: ;
    endcase
  end

  // R10
  cfg_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cfg |=> (mcen_o == $past(bus_wdata[MCEN_LSB +: NSLICE])) &&
               (sel_o == $past(bus_wdata[SEL_LSB +: SELW])));
endmodule

// File: rtl/tgc_run_ctrl.sv
module tgc_run_ctrl #(
  parameter int NSLICE = 4,
  parameter int SELW   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSLICE-1:0] go_i,
  input  logic [NSLICE-1:0] halt_i,
  input  logic              psc_go_i,
  input  logic              psc_halt_i,
  input  logic              cnt_clr_i,
  input  logic [SELW-1:0]   sel_i,
  output logic [NSLICE-1:0] idle_o,
  output logic              psc_run_o,
  output logic              psc_clr_o
);
  logic [NSLICE-1:0] idle_d;
  logic              fall;
  logic              sel_valid;
  logic              tracked_idle;

  assign idle_d = (idle_o & ~go_i) | halt_i;

  always_comb begin
    fall         = 1'b0;
    sel_valid    = 1'b0;
    tracked_idle = 1'b0;
    for (int k = 0; k < NSLICE; k++) begin
      if (sel_i == SELW'(k+1)) begin
        fall         = ~idle_o[k] & idle_d[k];
        sel_valid    = 1'b1;
        tracked_idle = idle_o[k];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_o    <= '1;
      psc_run_o <= 1'b0;
      psc_clr_o <= 1'b0;
    end else begin
      idle_o    <= idle_d;
      psc_clr_o <= cnt_clr_i | fall;
      if (psc_halt_i || fall) psc_run_o <= 1'b0;
      else if (psc_go_i)      psc_run_o <= 1'b1;
    end
  end

  // R1
  halt_idles_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_i != '0) |=> ((idle_o & $past(halt_i)) == $past(halt_i)));
  // R1
  go_runs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((go_i & ~halt_i) != '0) |=> ((idle_o & $past(go_i & ~halt_i)) == '0));
  // R2
  psc_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    psc_halt_i |=> !psc_run_o);
  // R3
  cnt_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr_i |=> psc_clr_o);
  // R4
  auto_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_valid && $past(sel_i) == sel_i && $rose(tracked_idle))
      |-> (!psc_run_o && psc_clr_o));
endmodule

// File: rtl/tgc_req_bank.sv
module tgc_req_bank
  import tgc_pkg::*;
#(
  parameter int NSLICE = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSLICE-1:0] mc_req_i,
  input  logic [NSLICE-1:0] mcen_i,
  input  depth_e            depth_i,
  input  logic [NSLICE-1:0] set_pc_i,
  input  logic [NSLICE-1:0] set_dith_i,
  input  logic [NSLICE-1:0] set_psc_i,
  input  logic [NSLICE-1:0] clr_pc_i,
  input  logic [NSLICE-1:0] clr_dith_i,
  input  logic [NSLICE-1:0] clr_psc_i,
  input  logic [NSLICE-1:0] sts_set_i,
  input  logic [NSLICE-1:0] sts_clr_i,
  input  logic [NSLICE-1:0] ack_pc_i,
  input  logic [NSLICE-1:0] ack_dith_i,
  input  logic [NSLICE-1:0] ack_psc_i,
  output logic [NSLICE-1:0] pc_o,
  output logic [NSLICE-1:0] dith_o,
  output logic [NSLICE-1:0] psc_o,
  output logic [NSLICE-1:0] sts_o
);
  logic want_psc, want_dith;
  assign want_psc  = (depth_i != DEP_PC);
  assign want_dith = (depth_i == DEP_ALL);

  for (genvar i = 0; i < NSLICE; i++) begin : g_slice
    logic hw;
    assign hw = mc_req_i[i] & mcen_i[i];

    tgc_flag u_pc (
      .clk(clk), .rst_n(rst_n),
      .set_i(set_pc_i[i] | hw), .clr_i(clr_pc_i[i]), .ack_i(ack_pc_i[i]),
      .q_o(pc_o[i]));
    tgc_flag u_dith (
      .clk(clk), .rst_n(rst_n),
      .set_i(set_dith_i[i] | (hw & want_dith)), .clr_i(clr_dith_i[i]),
      .ack_i(ack_dith_i[i]), .q_o(dith_o[i]));
    tgc_flag u_psc (
      .clk(clk), .rst_n(rst_n),
      .set_i(set_psc_i[i] | (hw & want_psc)), .clr_i(clr_psc_i[i]),
      .ack_i(ack_psc_i[i]), .q_o(psc_o[i]));
    tgc_flag u_sts (
      .clk(clk), .rst_n(rst_n),
      .set_i(sts_set_i[i]), .clr_i(sts_clr_i[i]), .ack_i(1'b0),
      .q_o(sts_o[i]));

    // R7
    mc_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!mcen_i[i] && !set_pc_i[i] && !pc_o[i]) |=> !pc_o[i]);
    // R8
    full_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mc_req_i[i] && mcen_i[i] && depth_i == DEP_ALL) |=> (dith_o[i] && psc_o[i]));
    // R8
    pc_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (depth_i == DEP_PC && !set_dith_i[i] && !dith_o[i]) |=> !dith_o[i]);
  end
endmodule

// File: rtl/tmr_glb_ctrl.sv
module tmr_glb_ctrl
  import tgc_pkg::*;
#(
  parameter int NSLICE = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic [NSLICE-1:0] mc_req,
  input  logic [NSLICE-1:0] ack_pc,
  input  logic [NSLICE-1:0] ack_dith,
  input  logic [NSLICE-1:0] ack_psc,
  output logic [NSLICE-1:0] slice_run,
  output logic              psc_run,
  output logic              psc_clr,
  output logic [NSLICE-1:0] pend_pc,
  output logic [NSLICE-1:0] pend_dith,
  output logic [NSLICE-1:0] pend_psc,
  output logic [NSLICE-1:0] sw_stat
);
  localparam int SELW = $clog2(NSLICE+1);

  logic [SELW-1:0]   sel;
  logic [NSLICE-1:0] mcen, go, halt, idle;
  depth_e            depth;
  logic              psc_go, psc_halt, cnt_clr;
  logic [NSLICE-1:0] set_pc, set_dith, set_psc, clr_pc, clr_dith, clr_psc;
  logic [NSLICE-1:0] sts_set, sts_clr;

  tgc_regif #(.NSLICE(NSLICE)) u_regif (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sel_o(sel), .mcen_o(mcen), .depth_o(depth),
    .go_o(go), .halt_o(halt), .psc_go_o(psc_go), .psc_halt_o(psc_halt),
    .cnt_clr_o(cnt_clr),
    .set_pc_o(set_pc), .set_dith_o(set_dith), .set_psc_o(set_psc),
    .clr_pc_o(clr_pc), .clr_dith_o(clr_dith), .clr_psc_o(clr_psc),
    .sts_set_o(sts_set), .sts_clr_o(sts_clr),
    .idle_i(idle), .psc_run_i(psc_run), .pc_i(pend_pc), .dith_i(pend_dith),
    .psc_i(pend_psc), .sts_i(sw_stat));

  tgc_run_ctrl #(.NSLICE(NSLICE), .SELW(SELW)) u_run (
    .clk(clk), .rst_n(rst_n), .go_i(go), .halt_i(halt),
    .psc_go_i(psc_go), .psc_halt_i(psc_halt), .cnt_clr_i(cnt_clr),
    .sel_i(sel), .idle_o(idle), .psc_run_o(psc_run), .psc_clr_o(psc_clr));

  tgc_req_bank #(.NSLICE(NSLICE)) u_req (
    .clk(clk), .rst_n(rst_n), .mc_req_i(mc_req), .mcen_i(mcen),
    .depth_i(depth),
    .set_pc_i(set_pc), .set_dith_i(set_dith), .set_psc_i(set_psc),
    .clr_pc_i(clr_pc), .clr_dith_i(clr_dith), .clr_psc_i(clr_psc),
    .sts_set_i(sts_set), .sts_clr_i(sts_clr),
    .ack_pc_i(ack_pc), .ack_dith_i(ack_dith), .ack_psc_i(ack_psc),
    .pc_o(pend_pc), .dith_o(pend_dith), .psc_o(pend_psc), .sts_o(sw_stat));

  assign slice_run = ~idle;
endmodule

// File: tb/tmr_glb_ctrl_tb.sv
module tmr_glb_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  mc_req = '0, ack_pc = '0, ack_dith = '0, ack_psc = '0;
  logic [3:0]  slice_run, pend_pc, pend_dith, pend_psc, sw_stat;
  logic        psc_run, psc_clr;

  int n_cmp = 0;
  int n_bad = 0;

  // bench model state
  logic [3:0] m_idle, m_pc, m_di, m_ps, m_st, m_en;
  logic [2:0] m_sel;
  logic [1:0] m_dep;
  logic       m_prun, m_pclr;

  always #5 clk = ~clk;

  tmr_glb_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mc_req(mc_req),
    .ack_pc(ack_pc), .ack_dith(ack_dith), .ack_psc(ack_psc),
    .slice_run(slice_run), .psc_run(psc_run), .psc_clr(psc_clr),
    .pend_pc(pend_pc), .pend_dith(pend_dith), .pend_psc(pend_psc),
    .sw_stat(sw_stat));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic fnext(input logic q, input logic s, input logic c);
    return s ? 1'b1 : (c ? 1'b0 : q);
  endfunction

  function automatic logic [31:0] exp_read(input logic [3:0] a);
    logic [31:0] r = '0;
    case (a)
      4'd0: begin r[2:0] = m_sel; r[7:4] = m_en; r[13:12] = m_dep; end
      4'd3: begin r[3:0] = m_idle; r[8] = m_prun; end
      4'd6: for (int i = 0; i < 4; i++) begin
              r[3*i] = m_pc[i]; r[3*i+1] = m_di[i]; r[3*i+2] = m_ps[i];
              r[16+i] = m_st[i];
            end
      default: ;
    endcase
    return r;
  endfunction

  task automatic model_reset();
    m_idle = 4'hF; m_pc = '0; m_di = '0; m_ps = '0; m_st = '0; m_en = '0;
    m_sel = '0; m_dep = '0; m_prun = 1'b0; m_pclr = 1'b0;
  endtask

  task automatic compare_ports();
    chk("R1", {28'd0, slice_run}, {28'd0, ~m_idle});
    chk("R2 R4", {31'd0, psc_run}, {31'd0, m_prun});
    chk("R3 R4", {31'd0, psc_clr}, {31'd0, m_pclr});
    chk("R5 R6 R7 R8 pc", {28'd0, pend_pc}, {28'd0, m_pc});
    chk("R5 R6 R7 R8 dith", {28'd0, pend_dith}, {28'd0, m_di});
    chk("R5 R6 R7 R8 psc", {28'd0, pend_psc}, {28'd0, m_ps});
    chk("R9", {28'd0, sw_stat}, {28'd0, m_st});
  endtask

  // one clock cycle with the given stimulus; model advanced alongside
  task automatic cyc(input logic wr, input logic [3:0] a, input logic [31:0] d,
                     input logic [3:0] mc, input logic [3:0] apc,
                     input logic [3:0] adi, input logic [3:0] aps);
    logic [3:0] go, halt, n_idle, s_pc, s_di, s_ps, n_pc, n_di, n_ps, n_st;
    logic fall, n_prun;
    @(negedge clk);
    bus_wr = wr; bus_addr = a; bus_wdata = d;
    mc_req = mc; ack_pc = apc; ack_dith = adi; ack_psc = aps;
    go   = (wr && a == 4'd1) ? d[3:0] : 4'd0;
    halt = (wr && a == 4'd2) ? d[3:0] : 4'd0;
    n_idle = (m_idle & ~go) | halt;
    fall = (m_sel >= 3'd1 && m_sel <= 3'd4) &&
           !m_idle[m_sel-3'd1] && n_idle[m_sel-3'd1];
    n_prun = ((wr && a == 4'd2 && d[8]) || fall) ? 1'b0 :
             ((wr && a == 4'd1 && d[8]) ? 1'b1 : m_prun);
    for (int i = 0; i < 4; i++) begin
      logic hw, sw_s, sw_c;
      hw = mc[i] & m_en[i];
      s_pc[i] = (wr && a == 4'd4 && d[3*i])   | hw;
      s_di[i] = (wr && a == 4'd4 && d[3*i+1]) | (hw && m_dep == 2'd3);
      s_ps[i] = (wr && a == 4'd4 && d[3*i+2]) | (hw && m_dep != 2'd0);
      n_pc[i] = fnext(m_pc[i], s_pc[i], (wr && a == 4'd5 && d[3*i])   | apc[i]);
      n_di[i] = fnext(m_di[i], s_di[i], (wr && a == 4'd5 && d[3*i+1]) | adi[i]);
      n_ps[i] = fnext(m_ps[i], s_ps[i], (wr && a == 4'd5 && d[3*i+2]) | aps[i]);
      sw_s = wr && a == 4'd4 && d[16+i];
      sw_c = wr && a == 4'd5 && d[16+i];
      n_st[i] = fnext(m_st[i], sw_s, sw_c);
    end
    @(posedge clk);
    #1;
    m_pclr = (wr && a == 4'd2 && d[9]) || fall;
    m_idle = n_idle; m_prun = n_prun;
    m_pc = n_pc; m_di = n_di; m_ps = n_ps; m_st = n_st;
    if (wr && a == 4'd0) begin
      m_sel = d[2:0]; m_en = d[7:4]; m_dep = d[13:12];
    end
    compare_ports();
  endtask

  task automatic rd(input logic [3:0] a, input string tag);
    bus_wr = 1'b0; bus_addr = a;
    #1;
    chk(tag, bus_rdata, exp_read(a));
  endtask

  task automatic wr1(input logic [3:0] a, input logic [31:0] d);
    cyc(1'b1, a, d, 4'd0, 4'd0, 4'd0, 4'd0);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #2_000_000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240517));
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    // R10: reset contents, write-only and unmapped words read 0
    chk("R10 run stat", bus_rdata & 32'h0, 32'h0);
    rst_n = 1'b1;
    #1;
    compare_ports();
    bus_addr = 4'd3; #1; chk("R10 idle after reset", bus_rdata, 32'h0000_000F);
    bus_addr = 4'd6; #1; chk("R10 flags after reset", bus_rdata, 32'h0);
    bus_addr = 4'd0; #1; chk("R10 cfg after reset", bus_rdata, 32'h0);

    // R10: configuration readback, write-only words read 0
    wr1(4'd0, 32'h0000_3052);          // sel=2, en=0101, depth=3
    rd(4'd0, "R10 cfg readback");
    chk("R10 cfg value", bus_rdata, 32'h0000_3052);
    wr1(4'd1, 32'hFFFF_FFFF);
    rd(4'd1, "R10 go word reads 0");
    rd(4'd2, "R10 halt word reads 0");
    rd(4'd4, "R10 set word reads 0");
    rd(4'd5, "R10 clr word reads 0");
    rd(4'd9, "R10 unmapped reads 0");
    rd(4'd3, "R1 R2 run status");
    chk("R1 R2 all running", bus_rdata, 32'h0000_0100);

    // R4: stopping slice 1 with select code 2 stops and clears the prescaler
    wr1(4'd2, 32'h0000_0002);
    chk("R4 auto stop", {31'd0, psc_run}, 32'd0);
    chk("R4 auto clear pulse", {31'd0, psc_clr}, 32'd1);
    wr1(4'd1, 32'h0000_0100);
    wr1(4'd2, 32'h0000_0001);          // slice 0 not selected
    chk("R4 other slice no stop", {31'd0, psc_run}, 32'd1);
    // R3: count clear pulse lasts one cycle
    wr1(4'd2, 32'h0000_0200);
    chk("R3 pulse", {31'd0, psc_clr}, 32'd1);
    cyc(1'b0, 4'd0, 32'd0, 4'd0, 4'd0, 4'd0, 4'd0);
    chk("R3 pulse ends", {31'd0, psc_clr}, 32'd0);

    // R5: trigger set wins over software clear in the same cycle (slice 0 enabled)
    cyc(1'b1, 4'd5, 32'h0000_0001, 4'b0001, 4'd0, 4'd0, 4'd0);
    chk("R5 set beats clear", {31'd0, pend_pc[0]}, 32'd1);
    chk("R8 depth 3 dither", {31'd0, pend_dith[0]}, 32'd1);
    // R6: acknowledge with a concurrent set keeps the flag
    cyc(1'b1, 4'd4, 32'h0000_0001, 4'd0, 4'b0001, 4'd0, 4'd0);
    chk("R6 set beats ack", {31'd0, pend_pc[0]}, 32'd1);
    cyc(1'b0, 4'd0, 32'd0, 4'd0, 4'b0001, 4'd0, 4'd0);
    chk("R6 ack clears", {31'd0, pend_pc[0]}, 32'd0);
    // R7: disabled slice 1 trigger ignored
    cyc(1'b0, 4'd0, 32'd0, 4'b0010, 4'd0, 4'd0, 4'd0);
    chk("R7 disabled trigger", {29'd0, pend_pc[1], pend_dith[1], pend_psc[1]}, 32'd0);
    // R8: reserved depth code 2 acts like 1
    wr1(4'd0, 32'h0000_20F0);
    wr1(4'd5, 32'h000F_0FFF);
    cyc(1'b0, 4'd0, 32'd0, 4'b0100, 4'd0, 4'd0, 4'd0);
    chk("R8 depth 2", {29'd0, pend_pc[2], pend_dith[2], pend_psc[2]}, 32'b101);
    // R9: software status set and readback
    wr1(4'd4, 32'h0005_0000);
    rd(4'd6, "R9 status readback");

    // constrained random mix
    for (int n = 0; n < 3000; n++) begin
      logic [3:0]  a;
      logic [31:0] d;
      a = 4'($urandom % 8);
      d = $urandom;
      if (a == 4'd0 && ($urandom % 4) != 0) d[2:0] = 3'($urandom % 5);
      cyc(($urandom % 3) != 0, a, d,
          4'($urandom & $urandom), 4'($urandom & $urandom & $urandom),
          4'($urandom & $urandom & $urandom), 4'($urandom & $urandom & $urandom));
      if ((n % 5) == 0) rd(4'($urandom % 8), "R10 R1 R2 R5 R9 random read");
    end

    finish_run();
  end
endmodule